// File: doc/BRIEF.md
# Translation Buffer Pointer Generator

When a translation lookaside buffer misses, a software or hardware refill handler must find the entry for that virtual page in an in-memory translation storage buffer. This block forms the address of that entry. It keeps one group of buffer bases and one page-size config word for the data side and another for the instruction side. Each group has one set for context zero and one set for all other contexts. Each set holds a base for size class 0, a base for size class 1 and one config word.

A request presents a virtual address and a 13-bit context, which together form a 64-bit tag word: the virtual page in bits 63:13 and the context in bits 12:0. The block looks up the context set, the page-size code and the buffer size. It then merges the shifted tag into the base and returns a 16-byte aligned pointer one cycle later. A single request returns the pointer for one side and one size class. A request in all-pointers mode returns all four pointers at once. Fetching the buffer entry from memory is left to the caller.

Top module: `tsbp_gen`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0, every pointer slot is 0 and every base and config register is 0. A request issued before any write therefore returns tag bits 21:13 placed at pointer bits 12:4 and zero elsewhere.
- R2: When bits 12:0 of the tag word (the context) are all zero, the context-zero set of the addressed side is used. Any nonzero context uses the nonzero-context set.
- R3: Pointer bits 63:13 start as bits 63:13 of the selected base. Base bits 12:0 never reach the pointer directly.
- R4: Base bits 3:0 give a buffer size exponent `e`. The tag word, shifted right, is masked to bits (12+e) down to 4 and ORed into the pointer.
- R5: The page-size code is config bits 2:0 for size class 0 and config bits 10:8 for size class 1. The tag word is shifted right by 9 + 3 × code.
- R6: For size class 1 only, if base bit 12 (the split flag) is 1, pointer bit 13+e is set. For size class 0 the split flag has no effect.
- R7: Bits 3:0 of every pointer slot are always 0.
- R8: A request sampled with `req_valid` high gives `rsp_valid` high in the next cycle, with the result in `rsp_ptr`. A cycle with no request gives `rsp_valid` low, and `rsp_ptr` holds its last value.
- R9: A register write in the same cycle as a request does not affect that request. It takes effect for the next request.
- R10: In all-pointers mode (`req_all`=1), slot 0 (bits 63:0) holds data class 0, slot 1 holds data class 1, slot 2 holds instruction class 0 and slot 3 (bits 255:192) holds instruction class 1. In single mode, slot 0 holds the pointer for `req_side` (0 data, 1 instruction) and `req_class`, and slots 1 to 3 are 0.
- R11: A write stores `wr_data` into the register chosen by `wr_side` (0 data, 1 instruction), `wr_set` (0 context zero, 1 nonzero context) and `wr_kind` (0 class-0 base, 1 class-1 base, 2 config). `wr_kind`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_side | input | 1 | Write target side: 0 data, 1 instruction |
| wr_set | input | 1 | Write target set: 0 context zero, 1 nonzero context |
| wr_kind | input | 2 | 0 class-0 base, 1 class-1 base, 2 config, 3 none |
| wr_data | input | 64 | Write value |
| req_valid | input | 1 | Request strobe |
| req_all | input | 1 | 1 returns all four pointers |
| req_side | input | 1 | Side for single mode |
| req_class | input | 1 | Size class for single mode |
| req_va | input | 64 | Virtual address; bits 63:13 are used |
| req_ctx | input | 13 | Context forming tag bits 12:0 |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_all | output | 1 | Mode of the returned result |
| rsp_ptr | output | 256 | Four 64-bit pointer slots, slot 0 in the low bits |

## Verification
The handshake assertions assume that `req_valid` is always 0 or 1 after reset. They also assume that any cycle without a request leaves `rsp_ptr` untouched, so the bench drives the request strobe to a defined level from time zero and drops it between requests. The alignment and single-mode checks assume that requests carry defined addresses, contexts and register contents. The sweep writes every register with fully defined pseudo-random words before each batch of requests. These words cover all sixteen size exponents, all eight page-size codes, both split states, and contexts both zero and nonzero.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int DW       = 64;  // word width
  localparam int CTX_W    = 13;  // context field width in the tag word
  localparam int EXP_W    = 4;   // buffer size exponent width
  localparam int CODE_W   = 3;   // page-size code width
  localparam int SPLIT_B  = 12;  // split flag position in a base
  localparam int CODE0_LO = 0;   // page-size code for class 0
  localparam int CODE1_LO = 8;   // page-size code for class 1
  localparam int SHIFT_W  = 6;
  localparam int SIDES    = 2;
  localparam int SETS     = 2;
  localparam int SLOTS    = SIDES * 2;

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    word_t base0;
    word_t base1;
    word_t cfg;
  } regset_t;

  typedef enum logic [1:0] {
    K_BASE0 = 2'd0,
    K_BASE1 = 2'd1,
    K_CFG   = 2'd2,
    K_NONE  = 2'd3
  } wkind_e;
endpackage

// File: rtl/tsbp_regs.sv
module tsbp_regs
  import tsbp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_side,
  input  logic                          wr_set,
  input  logic [1:0]                    wr_kind,
  input  word_t                         wr_data,
  output regset_t [SIDES-1:0][SETS-1:0] sets_o
);
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar t = 0; t < SETS; t++) begin : g_set
      regset_t q, d;
      logic    hit;

      always_comb begin
        hit = wr_en && (wr_side == 1'(s)) && (wr_set == 1'(t));
        d   = q;
        if (hit) begin
          case (wkind_e'(wr_kind))
            K_BASE0: d.base0 = wr_data;
            K_BASE1: d.base1 = wr_data;
            K_CFG:   d.cfg   = wr_data;
            default: d       = q;
          endcase
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= d;
      end

      assign sets_o[s][t] = q;
    end
  end

  // R11
  ignore_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'd3) |=> $stable(sets_o));
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc
  import tsbp_pkg::*;
(
  input  regset_t zset,
  input  regset_t nset,
  input  word_t   tag,
  input  logic    cls,
  output word_t   ptr
);
  regset_t             sel;
  word_t               base;
  logic [EXP_W-1:0]    sz_exp;
  logic [CODE_W-1:0]   code;
  logic [SHIFT_W-1:0]  shamt;
  logic [SHIFT_W-1:0]  top_bit;
  word_t               mask;
  word_t               split_bit;

  always_comb begin
    sel       = (tag[CTX_W-1:0] == '0) ? zset : nset;
    base      = cls ? sel.base1 : sel.base0;
    sz_exp    = base[EXP_W-1:0];
    code      = cls ? sel.cfg[CODE1_LO +: CODE_W] : sel.cfg[CODE0_LO +: CODE_W];
    shamt     = SHIFT_W'(9) + SHIFT_W'(code) * SHIFT_W'(3);
    top_bit   = SHIFT_W'(CTX_W) + SHIFT_W'(sz_exp);
    mask      = ((word_t'(1) << top_bit) - word_t'(1)) & ~word_t'(15);
    split_bit = (cls && base[SPLIT_B]) ? (word_t'(1) << top_bit) : '0;
    ptr       = {base[DW-1:CTX_W], {CTX_W{1'b0}}} | split_bit | ((tag >> shamt) & mask);
  end
endmodule

// File: rtl/tsbp_gen.sv
module tsbp_gen
  import tsbp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_side,
  input  logic                  wr_set,
  input  logic [1:0]            wr_kind,
  input  logic [DW-1:0]         wr_data,
  input  logic                  req_valid,
  input  logic                  req_all,
  input  logic                  req_side,
  input  logic                  req_class,
  input  logic [DW-1:0]         req_va,
  input  logic [CTX_W-1:0]      req_ctx,
  output logic                  rsp_valid,
  output logic                  rsp_all,
  output logic [SLOTS*DW-1:0]   rsp_ptr
);
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  regset_t [SIDES-1:0][SETS-1:0] sets;

  tsbp_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_ok),
    .wr_en   (wr_en),
    .wr_side (wr_side),
    .wr_set  (wr_set),
    .wr_kind (wr_kind),
    .wr_data (wr_data),
    .sets_o  (sets)
  );

  word_t tag;
  assign tag = {req_va[DW-1:CTX_W], req_ctx};

  logic [SLOTS*DW-1:0] ptr_d, ptr_q;
  logic                valid_q, all_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int SD = k / 2;
    localparam int CL = k % 2;
    logic  side_k, cls_k;
    word_t raw;

    always_comb begin
      if (k == 0) begin
        side_k = req_all ? 1'b0 : req_side;
        cls_k  = req_all ? 1'b0 : req_class;
      end else begin
        side_k = (SD != 0);
        cls_k  = (CL != 0);
      end
    end

    tsbp_ptr_calc u_calc (
      .zset (sets[side_k][0]),
      .nset (sets[side_k][1]),
      .tag  (tag),
      .cls  (cls_k),
      .ptr  (raw)
    );

    always_comb ptr_d[k*DW +: DW] = (k == 0 || req_all) ? raw : '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      valid_q <= 1'b0;
      all_q   <= 1'b0;
      ptr_q   <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        all_q <= req_all;
        ptr_q <= ptr_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_all   = all_q;
  assign rsp_ptr   = ptr_q;

  // R8
  rsp_on_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> rsp_valid);
  // R8
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |=> (!rsp_valid && $stable(rsp_ptr)));
  // R10
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && !rsp_all) |-> (rsp_ptr[SLOTS*DW-1:DW] == '0));
  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |-> (rsp_ptr[3:0] == 4'd0 && rsp_ptr[DW+3:DW] == 4'd0 &&
                   rsp_ptr[2*DW+3:2*DW] == 4'd0 && rsp_ptr[3*DW+3:3*DW] == 4'd0));
endmodule

// File: tb/tsbp_gen_tb.sv
module tsbp_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_side = 1'b0, wr_set = 1'b0;
  logic [1:0]   wr_kind = 2'd0;
  logic [63:0]  wr_data = '0;
  logic         req_valid = 1'b0, req_all = 1'b0, req_side = 1'b0, req_class = 1'b0;
  logic [63:0]  req_va = '0;
  logic [12:0]  req_ctx = '0;
  logic         rsp_valid, rsp_all;
  logic [255:0] rsp_ptr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  // model registers [side][set]
  logic [63:0] mb0 [2][2];
  logic [63:0] mb1 [2][2];
  logic [63:0] mcf [2][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsbp_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_set(wr_set),
    .wr_kind(wr_kind), .wr_data(wr_data), .req_valid(req_valid), .req_all(req_all),
    .req_side(req_side), .req_class(req_class), .req_va(req_va), .req_ctx(req_ctx),
    .rsp_valid(rsp_valid), .rsp_all(rsp_all), .rsp_ptr(rsp_ptr)
  );

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [63:0] model_ptr(int side, int cls, logic [63:0] tag);
    int set = (tag[12:0] == 13'd0) ? 0 : 1;
    logic [63:0] b  = (cls == 1) ? mb1[side][set] : mb0[side][set];
    logic [63:0] cf = mcf[side][set];
    int e    = int'(b[3:0]);
    int code = (cls == 1) ? int'(cf[10:8]) : int'(cf[2:0]);
    logic [63:0] off = tag >> (9 + 3 * code);
    logic [63:0] r;
    off = off % (64'd1 << (13 + e));
    off = off - (off % 64'd16);
    r = (b >> 13) << 13;
    r = r | off;
    if (cls == 1 && b[12]) r = r | (64'd1 << (13 + e));
    return r;
  endfunction

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int side, int set, int kind, logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_side = 1'(side); wr_set = 1'(set); wr_kind = 2'(kind); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (kind == 0) mb0[side][set] = data;
    else if (kind == 1) mb1[side][set] = data;
    else if (kind == 2) mcf[side][set] = data;
  endtask

  // computes expectations from the model state at issue time
  task automatic req(string tagname, bit all, int side, int cls,
                     logic [63:0] va, logic [12:0] ctx, bit with_wr, int wkind,
                     logic [63:0] wdata);
    logic [63:0] exp_s [4];
    logic [63:0] t = {va[63:13], ctx};
    for (int k = 0; k < 4; k++) begin
      if (all) exp_s[k] = model_ptr(k / 2, k % 2, t);
      else     exp_s[k] = (k == 0) ? model_ptr(side, cls, t) : 64'd0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_all = all; req_side = 1'(side); req_class = 1'(cls);
    req_va = va; req_ctx = ctx;
    if (with_wr) begin
      wr_en = 1'b1; wr_side = 1'(side); wr_set = (ctx == 13'd0) ? 1'b0 : 1'b1;
      wr_kind = 2'(wkind); wr_data = wdata;
    end
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    if (with_wr) begin
      if (wkind == 0) mb0[side][(ctx == 13'd0) ? 0 : 1] = wdata;
      else if (wkind == 1) mb1[side][(ctx == 13'd0) ? 0 : 1] = wdata;
      else if (wkind == 2) mcf[side][(ctx == 13'd0) ? 0 : 1] = wdata;
    end
    cmp({tagname, " R8 valid"}, 64'(rsp_valid), 64'd1);
    for (int k = 0; k < 4; k++) begin
      cmp(tagname, rsp_ptr[k*64 +: 64], exp_s[k]);
      cmp("R7 alignment", 64'(rsp_ptr[k*64 +: 4]), 64'd0);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] held;
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 2; t++) begin
        mb0[s][t] = '0; mb1[s][t] = '0; mcf[s][t] = '0;
      end
    repeat (4) @(negedge clk);
    cmp("R1 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1 valid after reset", 64'(rsp_valid), 64'd0);
    for (int k = 0; k < 4; k++) cmp("R1 slot after reset", rsp_ptr[k*64 +: 64], 64'd0);
    // R1: zero registers give tag bits placed at 12:4
    req("R1 zero regs", 1, 0, 0, 64'hDEAD_BEEF_CAFE_2000, 13'h0, 0, 0, 0);
    req("R1 zero regs", 1, 0, 0, 64'h0123_4567_89AB_CDEF, 13'h1A5, 0, 0, 0);

    // sweep of size exponents and page-size codes
    for (int e = 0; e < 16; e++) begin
      for (int c = 0; c < 8; c++) begin
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++) begin
            logic [63:0] b0 = rnd(), b1 = rnd(), cf = rnd();
            b0[3:0] = 4'((e + 5 * s + 3 * t) % 16);
            b1[3:0] = 4'((e + 7 * t + 2 * s) % 16);
            b0[12]  = (c + s) % 2 == 1;
            b1[12]  = (e + c + t) % 2 == 0;
            cf[2:0]  = 3'((c + s + t) % 8);
            cf[10:8] = 3'((c + 5 + s) % 8);
            wr(s, t, 0, b0);
            wr(s, t, 1, b1);
            wr(s, t, 2, cf);
          end
        // R2 R10: all-pointers with zero and nonzero contexts
        req("R2 R10 all ctx0", 1, 0, 0, rnd(), 13'h0, 0, 0, 0);
        req("R2 R10 all ctxN", 1, 0, 0, rnd(), 13'(1 + (e * 8 + c) % 8191), 0, 0, 0);
        req("R2 ctx bit12 only", 1, 0, 0, rnd(), 13'h1000, 0, 0, 0);
        // R3 R4 R5 R6: single-mode pointers per side and class
        for (int sd = 0; sd < 2; sd++)
          for (int cl = 0; cl < 2; cl++)
            req("R3 R4 R5 R6 R10 single", 0, sd, cl, rnd(),
                ((e + cl) % 2 == 0) ? 13'h0 : 13'(rnd()) | 13'h1, 0, 0, 0);
      end
    end

    // R8: idle cycle keeps result and drops valid
    req("R8 before idle", 1, 0, 0, rnd(), 13'h3, 0, 0, 0);
    held = rsp_ptr[127:64];
    @(negedge clk);
    cmp("R8 idle valid", 64'(rsp_valid), 64'd0);
    cmp("R8 idle hold", rsp_ptr[127:64], held);

    // R9: write in the same cycle as a request affects only the next one
    req("R9 same-cycle write", 0, 1, 1, 64'hFFFF_0000_1234_6000, 13'h0, 1, 1, 64'hA5A5_0000_0000_100F);
    req("R9 next request", 0, 1, 1, 64'hFFFF_0000_1234_6000, 13'h0, 0, 0, 0);
    req("R9 cfg same-cycle", 0, 0, 0, 64'h1357_9BDF_2468_A000, 13'h44, 1, 2, 64'h0000_0000_0000_0507);
    req("R9 cfg next", 0, 0, 0, 64'h1357_9BDF_2468_A000, 13'h44, 0, 0, 0);

    // R11: kind 3 changes no register
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 2; t++) wr(s, t, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    req("R11 ignored kind ctx0", 1, 0, 0, rnd(), 13'h0, 0, 0, 0);
    req("R11 ignored kind ctxN", 1, 0, 0, rnd(), 13'h7, 0, 0, 0);

    summary();
  end
endmodule